// File: doc/BRIEF.md
# Ring Reconfiguration Sequencer

This block is the central controller of a ring of pixel routers. It holds a short program of processing steps in an internal table. For each node, every step records four things: whether the node takes part, the routing word, the task code and the pixel budget. It also records a mode bit, which places the node in the chained pipeline (0) or takes its processing element out to work on a parallel task (1), and a flag that asks the frame store to deliver a stored flow to that node.

A start pulse latches the input/output node's loopback choice and begins step 0. For each step the controller enters a configuration phase. Each node's dedicated command link opens in its own slot, one cycle after the previous node's, and carries three beats. The controller then allows two cycles for the router to switch and one cycle for the processing element to change task, so each node's adaptation takes six cycles. When the configuration phase ends, the run phase waits until every participating node has sent its completion report (its pixel counter has run out). The controller then moves to the next step, or it pulses a finish flag after the last step set by `seq_last`.

Top module: `rrc_ring_ctrl`

## Requirements
- R1: After reset, busy, seq_done, io_loop, node_par, fs_req and cmd_valid are all zero, and step_idx is 0.
- R2: A start pulse while idle copies loop_en into io_loop and begins step 0. Its configuration phase starts in the cycle after the pulse.
- R3: In a configuration phase with timer t (0 in its first cycle), cmd_valid[n] is high exactly when node n takes part in the step and n <= t < n+3. A node that does not take part gets no command.
- R4: On node n's link the beat b = t-n carries {mode, route} zero-extended for b=0, with mode at bit ROUTE_W. It carries the task code for b=1 and the pixel count for b=2. cmd_word is zero outside a command.
- R5: fs_req[n] is a one-cycle pulse at t = n, issued only for a participating node whose memory flag is set.
- R6: busy is high for the whole configuration phase, NODES+5 cycles. This is the 6-cycle adaptation (3 command + 2 router + 1 element) of the last node slot. busy is low at all other times.
- R7: node_par[n] takes the step's mode bit of a participating node from timer value n+6 onward. A node that does not take part keeps its previous value.
- R8: The run phase lasts until every participating node has reported done, whether the reports arrive together or apart. The next step's configuration (step_idx+1) starts in the cycle after the last report.
- R9: Completion reports that arrive during the configuration phase, and reports from nodes that do not take part, have no effect on when the step advances.
- R10: A step with no participating node spends exactly one cycle in the run phase.
- R11: After step seq_last completes, seq_done is high for exactly one cycle, busy stays low, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin the step program (ignored unless idle) |
| loop_en | input | 1 | Loopback choice for the I/O node, latched on start |
| seq_last | input | STEP_W | Index of the final step |
| tbl_we | input | 1 | Table write strobe |
| tbl_step | input | STEP_W | Step index being written |
| tbl_node | input | NODE_W | Node index being written |
| tbl_act | input | 1 | Node takes part in this step |
| tbl_mode | input | 1 | 0 pipeline, 1 parallel (element taken out of the chain) |
| tbl_mem | input | 1 | Node needs a stored flow from the frame store |
| tbl_route | input | ROUTE_W | Routing word |
| tbl_task | input | TASK_W | Task code |
| tbl_count | input | PIX_W | Pixel budget |
| node_done | input | NODES | Per-node completion report pulses |
| busy | output | 1 | Configuration phase in progress |
| step_idx | output | STEP_W | Current step |
| seq_done | output | 1 | One-cycle pulse at program end |
| io_loop | output | 1 | Loopback setting of the I/O node |
| node_par | output | NODES | Per-node parallel mode state |
| fs_req | output | NODES | Per-node frame store request pulse |
| cmd_valid | output | NODES | Per-node command link valid |
| cmd_word | output | NODES*WORD_W | Per-node command beats, node n at [n*WORD_W +: WORD_W] |

## Verification
Two events can land in the same cycle. In the first, one node's completion report arrives in the same cycle as another node's still-outstanding report, so both must be merged before the step can advance. The bench provokes this with steps that give every node the same report delay. It then checks that the next configuration begins one cycle later and not two. In the second, completion reports arrive during a configuration phase while commands are still going out. The bench drives random reports throughout every configuration phase and judges that the run phase still waits for the real reports, by checking that step_idx holds and busy stays low until the last scheduled report.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

  typedef enum logic [1:0] {
    RRC_IDLE = 2'd0,
    RRC_CFG  = 2'd1,
    RRC_RUN  = 2'd2
  } rrc_state_e;

  // widest of three field widths: the command word must carry each beat
  function automatic int unsigned rrc_max3(input int unsigned a, input int unsigned b,
                                           input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // cycles one node needs from its first command beat to a settled datapath
  function automatic int unsigned rrc_adapt_span(input int unsigned cmd_cyc,
                                                 input int unsigned rcfg_cyc,
                                                 input int unsigned pe_cyc);
    return cmd_cyc + rcfg_cyc + pe_cyc;
  endfunction

endpackage

// File: rtl/rrc_step_table.sv
module rrc_step_table #(
  parameter int NODES   = 3,
  parameter int STEPS   = 4,
  parameter int ROUTE_W = 4,
  parameter int TASK_W  = 3,
  parameter int PIX_W   = 12,
  parameter int STEP_W  = $clog2(STEPS),
  parameter int NODE_W  = $clog2(NODES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [STEP_W-1:0]                wr_step,
  input  logic [NODE_W-1:0]                wr_node,
  input  logic                             wr_act,
  input  logic                             wr_mode,
  input  logic                             wr_mem,
  input  logic [ROUTE_W-1:0]               wr_route,
  input  logic [TASK_W-1:0]                wr_task,
  input  logic [PIX_W-1:0]                 wr_count,
  input  logic [STEP_W-1:0]                rd_step,
  output logic [NODES-1:0]                 rd_act,
  output logic [NODES-1:0]                 rd_mode,
  output logic [NODES-1:0]                 rd_mem,
  output logic [NODES-1:0][ROUTE_W-1:0]    rd_route,
  output logic [NODES-1:0][TASK_W-1:0]     rd_task,
  output logic [NODES-1:0][PIX_W-1:0]      rd_count
);

  logic [STEPS-1:0][NODES-1:0]              act_q, mode_q, mem_q;
  logic [STEPS-1:0][NODES-1:0][ROUTE_W-1:0] route_q;
  logic [STEPS-1:0][NODES-1:0][TASK_W-1:0]  task_q;
  logic [STEPS-1:0][NODES-1:0][PIX_W-1:0]   count_q;

  logic wr_hit;
  assign wr_hit = wr_en && (int'(wr_node) < NODES) && (int'(wr_step) < STEPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      mode_q  <= '0;
      mem_q   <= '0;
      route_q <= '0;
      task_q  <= '0;
      count_q <= '0;
    end else if (wr_hit) begin
      act_q[wr_step][wr_node]   <= wr_act;
      mode_q[wr_step][wr_node]  <= wr_mode;
      mem_q[wr_step][wr_node]   <= wr_mem;
      route_q[wr_step][wr_node] <= wr_route;
      task_q[wr_step][wr_node]  <= wr_task;
      count_q[wr_step][wr_node] <= wr_count;
    end
  end

  assign rd_act   = act_q[rd_step];
  assign rd_mode  = mode_q[rd_step];
  assign rd_mem   = mem_q[rd_step];
  assign rd_route = route_q[rd_step];
  assign rd_task  = task_q[rd_step];
  assign rd_count = count_q[rd_step];

endmodule

// File: rtl/rrc_cmd_sched.sv
module rrc_cmd_sched
  import rrc_pkg::*;
#(
  parameter int NODES    = 3,
  parameter int ROUTE_W  = 4,
  parameter int TASK_W   = 3,
  parameter int PIX_W    = 12,
  parameter int WORD_W   = 12,
  parameter int CMD_CYC  = 3,
  parameter int RCFG_CYC = 2,
  parameter int PE_CYC   = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_cfg,
  input  logic [NODES-1:0]                 act,
  input  logic [NODES-1:0]                 mode,
  input  logic [NODES-1:0]                 mem,
  input  logic [NODES-1:0][ROUTE_W-1:0]    route,
  input  logic [NODES-1:0][TASK_W-1:0]     task_code,
  input  logic [NODES-1:0][PIX_W-1:0]      count,
  output logic [NODES-1:0]                 cmd_valid,
  output logic [NODES-1:0][WORD_W-1:0]     cmd_word,
  output logic [NODES-1:0]                 fs_req,
  output logic [NODES-1:0]                 adapt_done,
  output logic                             cfg_last
);

  localparam int SPAN   = int'(rrc_adapt_span(CMD_CYC, RCFG_CYC, PE_CYC));
  localparam int T_LAST = NODES - 1 + SPAN - 1;
  localparam int TW     = $clog2(T_LAST + 1);

  logic [TW-1:0] t_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       t_q <= '0;
    else if (!in_cfg) t_q <= '0;
    else              t_q <= t_q + 1'b1;
  end

  assign cfg_last = in_cfg && (t_q == TW'(T_LAST));

  // beat b of one node's command: {mode,route}, task code, pixel budget
  function automatic logic [WORD_W-1:0] beat_word(input int beat, input logic md,
                                                  input logic [ROUTE_W-1:0] rt,
                                                  input logic [TASK_W-1:0] tk,
                                                  input logic [PIX_W-1:0] ct);
    case (beat)
      0:       return WORD_W'({md, rt});
      1:       return WORD_W'(tk);
      2:       return WORD_W'(ct);
      default: return '0;
    endcase
  endfunction

  for (genvar n = 0; n < NODES; n++) begin : g_link
    logic in_win;
    int   beat;
    always_comb begin
      beat         = int'(t_q) - n;
      in_win       = in_cfg && act[n] && (beat >= 0) && (beat < CMD_CYC);
      cmd_valid[n] = in_win;
      cmd_word[n]  = in_win ? beat_word(beat, mode[n], route[n], task_code[n], count[n])
                            : '0;
      fs_req[n]    = in_cfg && act[n] && mem[n] && (beat == 0);
      adapt_done[n] = in_cfg && act[n] && (beat == SPAN - 1);
    end
  end

endmodule

// File: rtl/rrc_done_track.sv
module rrc_done_track #(
  parameter int NODES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [NODES-1:0] act,
  input  logic [NODES-1:0] node_done,
  output logic             all_done
);

  logic [NODES-1:0] seen_q;
  logic [NODES-1:0] seen_now;

  assign seen_now = (seen_q | node_done) & act;
  assign all_done = run && (seen_now == act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   seen_q <= '0;
    else if (clr) seen_q <= '0;
    else if (run) seen_q <= seen_now;
  end

endmodule

// File: rtl/rrc_ring_ctrl.sv
module rrc_ring_ctrl
  import rrc_pkg::*;
#(
  parameter int NODES    = 3,
  parameter int STEPS    = 4,
  parameter int ROUTE_W  = 4,
  parameter int TASK_W   = 3,
  parameter int PIX_W    = 12,
  parameter int CMD_CYC  = 3,
  parameter int RCFG_CYC = 2,
  parameter int PE_CYC   = 1,
  parameter int STEP_W   = $clog2(STEPS),
  parameter int NODE_W   = $clog2(NODES),
  parameter int WORD_W   = int'(rrc_max3(ROUTE_W + 1, TASK_W, PIX_W))
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      loop_en,
  input  logic [STEP_W-1:0]         seq_last,
  input  logic                      tbl_we,
  input  logic [STEP_W-1:0]         tbl_step,
  input  logic [NODE_W-1:0]         tbl_node,
  input  logic                      tbl_act,
  input  logic                      tbl_mode,
  input  logic                      tbl_mem,
  input  logic [ROUTE_W-1:0]        tbl_route,
  input  logic [TASK_W-1:0]         tbl_task,
  input  logic [PIX_W-1:0]          tbl_count,
  input  logic [NODES-1:0]          node_done,
  output logic                      busy,
  output logic [STEP_W-1:0]         step_idx,
  output logic                      seq_done,
  output logic                      io_loop,
  output logic [NODES-1:0]          node_par,
  output logic [NODES-1:0]          fs_req,
  output logic [NODES-1:0]          cmd_valid,
  output logic [NODES*WORD_W-1:0]   cmd_word
);

  rrc_state_e state_q;
  logic [STEP_W-1:0] step_q;
  logic              loop_q;
  logic              fin_q;
  logic [NODES-1:0]  par_q;

  // named internal events
  logic in_cfg, run_phase, cfg_last, all_done, last_step, seq_end;
  logic [NODES-1:0] adapt_done;

  logic [NODES-1:0]              e_act, e_mode, e_mem;
  logic [NODES-1:0][ROUTE_W-1:0] e_route;
  logic [NODES-1:0][TASK_W-1:0]  e_task;
  logic [NODES-1:0][PIX_W-1:0]   e_count;
  logic [NODES-1:0][WORD_W-1:0]  word_pk;

  assign in_cfg    = (state_q == RRC_CFG);
  assign run_phase = (state_q == RRC_RUN);
  assign last_step = (step_q == seq_last);
  assign seq_end   = run_phase && all_done && last_step;

  rrc_step_table #(
    .NODES(NODES), .STEPS(STEPS), .ROUTE_W(ROUTE_W), .TASK_W(TASK_W),
    .PIX_W(PIX_W), .STEP_W(STEP_W), .NODE_W(NODE_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_step(tbl_step), .wr_node(tbl_node),
    .wr_act(tbl_act), .wr_mode(tbl_mode), .wr_mem(tbl_mem),
    .wr_route(tbl_route), .wr_task(tbl_task), .wr_count(tbl_count),
    .rd_step(step_q),
    .rd_act(e_act), .rd_mode(e_mode), .rd_mem(e_mem),
    .rd_route(e_route), .rd_task(e_task), .rd_count(e_count)
  );

  rrc_cmd_sched #(
    .NODES(NODES), .ROUTE_W(ROUTE_W), .TASK_W(TASK_W), .PIX_W(PIX_W),
    .WORD_W(WORD_W), .CMD_CYC(CMD_CYC), .RCFG_CYC(RCFG_CYC), .PE_CYC(PE_CYC)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .in_cfg(in_cfg),
    .act(e_act), .mode(e_mode), .mem(e_mem),
    .route(e_route), .task_code(e_task), .count(e_count),
    .cmd_valid(cmd_valid), .cmd_word(word_pk), .fs_req(fs_req),
    .adapt_done(adapt_done), .cfg_last(cfg_last)
  );

  rrc_done_track #(.NODES(NODES)) u_done (
    .clk(clk), .rst_n(rst_n), .clr(in_cfg), .run(run_phase),
    .act(e_act), .node_done(node_done), .all_done(all_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RRC_IDLE;
      step_q  <= '0;
      loop_q  <= 1'b0;
      fin_q   <= 1'b0;
    end else begin
      fin_q <= seq_end;
      case (state_q)
        RRC_IDLE: if (start) begin
          state_q <= RRC_CFG;
          step_q  <= '0;
          loop_q  <= loop_en;
        end
        RRC_CFG: if (cfg_last) state_q <= RRC_RUN;
        RRC_RUN: if (all_done) begin
          if (last_step) begin
            state_q <= RRC_IDLE;
          end else begin
            state_q <= RRC_CFG;
            step_q  <= step_q + 1'b1;
          end
        end
        default: state_q <= RRC_IDLE;
      endcase
    end
  end

  for (genvar n = 0; n < NODES; n++) begin : g_par
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             par_q[n] <= 1'b0;
      else if (adapt_done[n]) par_q[n] <= e_mode[n];
    end
  end

  assign busy     = in_cfg;
  assign step_idx = step_q;
  assign seq_done = fin_q;
  assign io_loop  = loop_q;
  assign node_par = par_q;
  assign cmd_word = word_pk;

endmodule

// File: rtl/rrc_ring_ctrl_chk.sv
module rrc_ring_ctrl_chk #(
  parameter int NODES   = 3,
  parameter int STEP_W  = 2,
  parameter int CMD_CYC = 3,
  parameter int SPAN    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [STEP_W-1:0] step_idx,
  input logic              seq_done,
  input logic [NODES-1:0]  node_par,
  input logic [NODES-1:0]  fs_req,
  input logic [NODES-1:0]  cmd_valid,
  input logic              run_phase,
  input logic [NODES-1:0]  adapt_done
);

  localparam int BUSY_LEN = NODES - 1 + SPAN;

  int bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;
  end

  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cmd_valid == '0) && (fs_req == '0));

  p_busy_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bcnt == BUSY_LEN);

  p_par_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(node_par));

  p_run_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_phase |-> !busy);

  p_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(run_phase)) |-> step_idx == $past(step_idx) + 1'b1);

  p_fin_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !busy && !run_phase && $past(run_phase));

  p_fin_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  for (genvar n = 0; n < NODES; n++) begin : g_node
    int vcnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            vcnt <= 0;
      else if (cmd_valid[n]) vcnt <= vcnt + 1;
      else                   vcnt <= 0;
    end

    p_cmd_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid[n] |-> vcnt < CMD_CYC);

    p_cmd_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_valid[n]) |-> vcnt == CMD_CYC);

    p_fs_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fs_req[n] |-> cmd_valid[n] && (vcnt == 0));

    p_fs_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fs_req[n] |=> !fs_req[n]);

    p_adapt_in_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      adapt_done[n] |-> busy && !cmd_valid[n]);
  end

endmodule

bind rrc_ring_ctrl rrc_ring_ctrl_chk #(
  .NODES(NODES), .STEP_W(STEP_W), .CMD_CYC(CMD_CYC),
  .SPAN(CMD_CYC + RCFG_CYC + PE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .step_idx(step_idx),
  .seq_done(seq_done), .node_par(node_par), .fs_req(fs_req),
  .cmd_valid(cmd_valid), .run_phase(run_phase), .adapt_done(adapt_done)
);

// File: tb/rrc_ring_ctrl_test.sv
module rrc_ring_ctrl_test;

  localparam int N    = 3;
  localparam int S    = 4;
  localparam int RW   = 4;
  localparam int TKW  = 3;
  localparam int PW   = 12;
  localparam int WW   = 12;
  localparam int CMD  = 3;
  localparam int SPAN = 6;
  localparam int TL   = N - 1 + SPAN - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic loop_en = 1'b0;
  logic [1:0] seq_last = '0;
  logic tbl_we = 1'b0;
  logic [1:0] tbl_step = '0;
  logic [1:0] tbl_node = '0;
  logic tbl_act = 1'b0, tbl_mode = 1'b0, tbl_mem = 1'b0;
  logic [RW-1:0] tbl_route = '0;
  logic [TKW-1:0] tbl_task = '0;
  logic [PW-1:0] tbl_count = '0;
  logic [N-1:0] node_done = '0;
  logic busy, seq_done, io_loop;
  logic [1:0] step_idx;
  logic [N-1:0] node_par, fs_req, cmd_valid;
  logic [N*WW-1:0] cmd_word;

  always #2 clk = ~clk;

  rrc_ring_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start), .loop_en(loop_en), .seq_last(seq_last),
    .tbl_we(tbl_we), .tbl_step(tbl_step), .tbl_node(tbl_node), .tbl_act(tbl_act),
    .tbl_mode(tbl_mode), .tbl_mem(tbl_mem), .tbl_route(tbl_route), .tbl_task(tbl_task),
    .tbl_count(tbl_count), .node_done(node_done), .busy(busy), .step_idx(step_idx),
    .seq_done(seq_done), .io_loop(io_loop), .node_par(node_par), .fs_req(fs_req),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word)
  );

  int checks = 0;
  int errors = 0;

  bit             b_act  [S][N];
  bit             b_mode [S][N];
  bit             b_mem  [S][N];
  logic [RW-1:0]  b_route[S][N];
  logic [TKW-1:0] b_task [S][N];
  logic [PW-1:0]  b_count[S][N];
  bit             exp_par[N];

  task automatic chk(input bit ok, input string tag, input longint unsigned a,
                     input longint unsigned e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, a, e, $time);
    end
  endtask

  function automatic logic [WW-1:0] exp_word(input int s, input int n, input int t);
    int b;
    b = t - n;
    if (!b_act[s][n] || b < 0 || b >= CMD) return '0;
    if (b == 0) return WW'({b_mode[s][n], b_route[s][n]});
    if (b == 1) return WW'(b_task[s][n]);
    return WW'(b_count[s][n]);
  endfunction

  function automatic bit exp_valid(input int s, input int n, input int t);
    return b_act[s][n] && (t >= n) && (t < n + CMD);
  endfunction

  task automatic put_entry(input int s, input int n);
    @(negedge clk);
    tbl_we = 1'b1; tbl_step = 2'(s); tbl_node = 2'(n);
    tbl_act = b_act[s][n]; tbl_mode = b_mode[s][n]; tbl_mem = b_mem[s][n];
    tbl_route = b_route[s][n]; tbl_task = b_task[s][n]; tbl_count = b_count[s][n];
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic fill_random();
    for (int s = 0; s < S; s++)
      for (int n = 0; n < N; n++) begin
        b_act[s][n]   = ($urandom % 4) != 0;
        b_mode[s][n]  = 1'($urandom);
        b_mem[s][n]   = 1'($urandom);
        b_route[s][n] = RW'($urandom);
        b_task[s][n]  = TKW'($urandom);
        b_count[s][n] = PW'($urandom);
        put_entry(s, n);
      end
  endtask

  task automatic run_seq(input int last, input bit loop, input bit same_dly);
    int dly[N];
    int maxc;
    @(negedge clk);
    start = 1'b1; loop_en = loop; seq_last = 2'(last);
    @(negedge clk);
    start = 1'b0;
    // now in the first configuration cycle (t = 0) of step 0
    chk(io_loop == loop, "R2 io_loop latched", io_loop, loop);
    for (int s = 0; s <= last; s++) begin
      for (int t = 0; t <= TL; t++) begin
        chk(busy == 1'b1, "R6 busy in config", busy, 1);
        chk(step_idx == 2'(s), "R8 step index", step_idx, s);
        chk(seq_done == 1'b0, "R11 no early finish", seq_done, 0);
        for (int n = 0; n < N; n++) begin
          bit pv;
          chk(cmd_valid[n] == exp_valid(s, n, t), "R3 command window", cmd_valid[n],
              exp_valid(s, n, t));
          chk(cmd_word[n*WW +: WW] == exp_word(s, n, t), "R4 command beat",
              cmd_word[n*WW +: WW], exp_word(s, n, t));
          chk(fs_req[n] == (b_act[s][n] && b_mem[s][n] && t == n), "R5 frame store request",
              fs_req[n], b_act[s][n] && b_mem[s][n] && t == n);
          pv = (b_act[s][n] && t >= n + SPAN) ? b_mode[s][n] : exp_par[n];
          chk(node_par[n] == pv, "R7 node mode during config", node_par[n], pv);
        end
        node_done = N'($urandom);  // R9: reports in config must be ignored
        @(negedge clk);
      end
      for (int n = 0; n < N; n++)
        if (b_act[s][n]) exp_par[n] = b_mode[s][n];
      maxc = 0;
      for (int n = 0; n < N; n++) begin
        dly[n] = same_dly ? 2 : int'($urandom % 5);
        if (b_act[s][n] && dly[n] > maxc) maxc = dly[n];
      end
      for (int c = 0; c <= maxc; c++) begin
        logic [N-1:0] drv;
        chk(busy == 1'b0, "R8 R9 R10 waiting in run phase", busy, 0);
        chk(step_idx == 2'(s), "R8 step held in run phase", step_idx, s);
        chk(cmd_valid == '0, "R3 no command in run phase", cmd_valid, 0);
        for (int n = 0; n < N; n++)
          chk(node_par[n] == exp_par[n], "R7 node mode after config", node_par[n], exp_par[n]);
        drv = '0;
        for (int n = 0; n < N; n++)
          if (b_act[s][n]) drv[n] = (dly[n] == c);
          else             drv[n] = 1'($urandom);  // R9: non-participant noise
        node_done = drv;
        @(negedge clk);
      end
    end
    node_done = '0;
    chk(seq_done == 1'b1, "R11 finish pulse", seq_done, 1);
    chk(busy == 1'b0, "R11 idle after finish", busy, 0);
    @(negedge clk);
    chk(seq_done == 1'b0, "R11 finish one cycle", seq_done, 0);
    chk(busy == 1'b0, "R11 stays idle", busy, 0);
    chk(io_loop == loop, "R2 io_loop held", io_loop, loop);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int n = 0; n < N; n++) exp_par[n] = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && seq_done == 1'b0 && io_loop == 1'b0, "R1 reset flags",
        {busy, seq_done, io_loop}, 0);
    chk(node_par == '0 && fs_req == '0 && cmd_valid == '0 && step_idx == '0,
        "R1 reset vectors", {node_par, fs_req, cmd_valid, step_idx}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && cmd_valid == '0, "R1 idle after reset", {busy, cmd_valid}, 0);

    fill_random();
    run_seq(3, 1'b1, 1'b0);

    // directed: empty step 1 (R10) and simultaneous reports (R8)
    for (int n = 0; n < N; n++) begin
      b_act[1][n] = 1'b0;
      put_entry(1, n);
      b_act[0][n] = 1'b1;
      b_act[2][n] = 1'b1;
      put_entry(0, n);
      put_entry(2, n);
    end
    run_seq(2, 1'b0, 1'b1);

    for (int i = 0; i < 6; i++) begin
      fill_random();
      run_seq(int'($urandom % 4), 1'($urandom), i == 2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule